// File: doc/BRIEF.md
# I2C Open-Drain Port Expander Slave

This block is an I2C target that owns eight open-drain general-purpose lines. A controller addresses it with a 7-bit address. The upper five bits of that address are a build parameter and the lower two come from strap inputs on the chip. After a write address, every data byte the controller sends goes straight to the eight line drivers. There is no register pointer. This continues for any number of bytes until a STOP. After a read address, the block returns the port levels that it captured during the address acknowledge.

The bus inputs and the pin inputs are brought into the system clock through two-flop synchronisers. All protocol decisions are taken on edges of the synchronised SCL. An active-low interrupt reports any difference between the live pin levels and the last captured snapshot. The interrupt stays asserted until the next matching address acknowledge takes a fresh snapshot.

Top module: `i2c_od_expander`

## Requirements
- R1: The device address is `{BASE_ADDR[6:2], addr_sel}`. After a matching address byte, `sda_pd` is 1 for the whole high phase of the ninth SCL clock. After a non-matching address byte, `sda_pd` stays 0.
- R2: In the address byte, a last bit of 0 selects a write. Every data byte of a write is acknowledged. Data bit i controls line i: a 1 releases the line (`pin_pd[i]`=0) and a 0 pulls it low (`pin_pd[i]`=1).
- R3: `pin_pd` changes only on the third system-clock edge after `scl_i` rises for the eighth data bit, and at no other time.
- R4: In one write transfer, each data byte is applied in turn until a STOP. The last byte applied stays on the lines.
- R5: During the acknowledge of any matching address, read or write, the synchronised pin levels are captured as the snapshot. The capture happens on the edge that handles the ninth SCL rise.
- R6: `int_n` goes to 0 on the third clock edge after `pin_i` comes to differ from the snapshot. It stays 0 even if the pins return to the snapshot value.
- R7: `int_n` returns to 1 only on the edge that takes a snapshot (R5).
- R8: In the address byte, a last bit of 1 selects a read. The block sends the snapshot MSB first, with bit i taken from line i. It sends the snapshot again for each byte the controller acknowledges. After a not-acknowledge it releases SDA until the next START.
- R9: A repeated START returns the block to address reception. Bytes that follow a non-matching address are neither acknowledged nor applied to the lines.
- R10: After a STOP, SCL clocks without a new START are ignored.
- R11: After reset, `pin_pd` is all zeros, `int_n` is 1, `sda_pd` is 0, and the snapshot is all ones.
- R12: `sda_pd` changes only on the edge that follows a synchronised SCL fall, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| addr_sel | input | 2 | Strap inputs that form the low address bits |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_pd | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Levels of the eight lines |
| pin_pd | output | 8 | Per-line pull-down enable, 1 pulls the line low |
| int_n | output | 1 | Active-low change interrupt, 1 = released |

## Verification
A corrupted bit counter or protocol state shows up at the ports within one byte. Either `sda_pd` is missing from, or misplaced in, the ninth-clock window, or `pin_pd` changes on the wrong edge or with a shifted value. The bench compares `pin_pd` and `int_n` against a model on every clock, so a mistimed port update or interrupt is caught on the exact cycle it occurs. A wrong snapshot appears only later: either as a read-back byte that differs from the captured pins, or as an interrupt that fires (or fails to fire) up to two transfers after the faulty capture.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } link_state_e;
endpackage

// File: rtl/i2cx_rst_sync.sv
module i2cx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2cx_bus_events.sv
module i2cx_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2cx_link_fsm.sv
module i2cx_link_fsm
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] snap_byte,
  output logic              sda_pd,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              snap_req
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

  link_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              ack_on_q, ack_on_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;
  logic [BYTE_W-1:0] rx_full;

  assign rx_full = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    ack_on_d = ack_on_q;
    rd_d     = rd_q;
    mack_d   = mack_q;
    wr_valid = 1'b0;
    wr_byte  = rx_full;
    snap_req = 1'b0;

    if (stop_det) begin
      state_d  = ST_IDLE;
      ack_on_d = 1'b0;
    end else if (start_det) begin
      state_d  = ST_ADDR;
      cnt_d    = '0;
      ack_on_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = rx_full;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (sh_q[ADDR_W-1:0] == dev_addr) begin
                state_d = ST_AACK;
                rd_d    = sda_s;
              end else begin
                state_d = ST_SKIP;
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_rise && ack_on_q) snap_req = 1'b1;
          if (scl_fall) begin
            if (!ack_on_q) begin
              ack_on_d = 1'b1;
            end else begin
              ack_on_d = 1'b0;
              cnt_d    = '0;
              if (rd_q) begin
                state_d = ST_RDATA;
                tx_d    = snap_byte;
              end else begin
                state_d = ST_WDATA;
              end
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = rx_full;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              wr_valid = 1'b1;
              state_d  = ST_WACK;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            if (!ack_on_q) begin
              ack_on_d = 1'b1;
            end else begin
              ack_on_d = 1'b0;
              cnt_d    = '0;
              state_d  = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) cnt_d = cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == ALL_BITS) state_d = ST_RACK;
            else                   tx_d    = {tx_q[BYTE_W-2:0], 1'b1};
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              tx_d    = snap_byte;
              cnt_d   = '0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '1;
      ack_on_q <= 1'b0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      ack_on_q <= ack_on_d;
      rd_q     <= rd_d;
      mack_q   <= mack_d;
    end
  end

  assign sda_pd = ack_on_q | ((state_q == ST_RDATA) & ~tx_q[BYTE_W-1]);
endmodule

// File: rtl/i2cx_port_bank.sv
module i2cx_port_bank
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_s,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              snap_req,
  output logic [BYTE_W-1:0] snap_byte,
  output logic [BYTE_W-1:0] pin_pd,
  output logic              int_n
);
  logic [BYTE_W-1:0] out_q, out_d;
  logic [BYTE_W-1:0] snap_q, snap_d;
  logic              irq_q, irq_d;
  logic              out_en, snap_en;

  always_comb begin
    out_en  = wr_valid;
    snap_en = snap_req;
    out_d   = wr_byte;
    snap_d  = pin_s;
    if (snap_req) irq_d = 1'b0;
    else          irq_d = irq_q | (pin_s != snap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '1;
      snap_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (out_en)  out_q  <= out_d;
      if (snap_en) snap_q <= snap_d;
      irq_q <= irq_d;
    end
  end

  assign pin_pd    = ~out_q;
  assign snap_byte = snap_q;
  assign int_n     = ~irq_q;
endmodule

// File: rtl/i2c_od_expander.sv
module i2c_od_expander
  import i2cx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h34,
  parameter int                SEL_W     = 2,
  parameter int                SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_pd,
  output logic              int_n
);
  logic              rst_int_n;
  logic              scl_s, sda_s;
  logic [BYTE_W-1:0] pin_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_valid, snap_req;
  logic [BYTE_W-1:0] wr_byte, snap_byte;
  logic [ADDR_W-1:0] dev_addr;

  assign dev_addr = {BASE_ADDR[ADDR_W-1:SEL_W], addr_sel};

  i2cx_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  i2cx_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cx_sync #(.W(BYTE_W), .STAGES(SYNC_STG), .RST_VAL({BYTE_W{1'b1}})) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d(pin_i), .q(pin_s)
  );

  i2cx_bus_events u_evt (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cx_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .snap_byte(snap_byte),
    .sda_pd(sda_pd), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .snap_req(snap_req)
  );

  i2cx_port_bank u_bank (
    .clk(clk), .rst_n(rst_int_n), .pin_s(pin_s),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .snap_req(snap_req),
    .snap_byte(snap_byte), .pin_pd(pin_pd), .int_n(int_n)
  );
endmodule

// File: rtl/i2cx_expander_chk.sv
module i2cx_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic       snap_req,
  input logic       sda_pd,
  input logic [7:0] pin_pd,
  input logic       int_n
);
  // R11: state seen right after reset release
  a_r11_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (pin_pd == 8'h00 && int_n && !sda_pd));

  // R3: lines move only after an SCL rise was handled
  a_r3_port_on_rise: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(pin_pd) |-> $past(scl_rise));

  // R12: SDA drive moves only after SCL fall, START or STOP
  a_r12_sda_after_fall: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sda_pd) |-> $past(scl_fall || start_det || stop_det));

  // R7: interrupt releases only with a snapshot
  a_r7_release_on_snap: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(int_n) |-> $past(snap_req));

  // R6: an asserted interrupt holds until a snapshot
  a_r6_int_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!int_n && !snap_req) |=> !int_n);
endmodule

bind i2c_od_expander i2cx_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n),
  .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .snap_req(snap_req), .sda_pd(sda_pd), .pin_pd(pin_pd), .int_n(int_n)
);

// File: tb/i2c_od_expander_tb.sv
module i2c_od_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WDOG       = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr_sel;
  logic       scl_m, sda_m;
  logic       sda_pd;
  logic [7:0] pin_drv;
  logic [7:0] pin_pd;
  logic       int_n;
  logic       sda_bus;

  assign sda_bus = sda_m & ~sda_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_od_expander u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_pd(sda_pd),
    .pin_i(pin_drv), .pin_pd(pin_pd), .int_n(int_n)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference model
  logic [7:0] m_out, m_snap, m_wr_val;
  logic       m_irq;
  bit         snap_pend, wr_pend, mdl_on;
  logic [7:0] pin_h[$];
  logic       scl_h[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 8'hFF; m_snap = 8'hFF; m_irq = 1'b0;
      snap_pend = 1'b0; wr_pend = 1'b0;
      pin_h = {}; scl_h = {};
      for (int i = 0; i < 4; i++) begin
        pin_h.push_front(8'hFF);
        scl_h.push_front(1'b1);
      end
    end else begin
      logic rise;
      pin_h.push_front(pin_drv); void'(pin_h.pop_back());
      scl_h.push_front(scl_m);   void'(scl_h.pop_back());
      rise = scl_h[2] && !scl_h[3];
      if (rise && snap_pend) begin
        m_snap = pin_h[2]; m_irq = 1'b0; snap_pend = 1'b0;
      end else if (pin_h[2] != m_snap) begin
        m_irq = 1'b1;
      end
      if (rise && wr_pend) begin
        m_out = m_wr_val; wr_pend = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on) begin
      chk("R3 pin_pd per cycle", {24'd0, pin_pd}, {24'd0, ~m_out});
      chk("R6 int_n per cycle", {31'd0, int_n}, {31'd0, ~m_irq});
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1'b1; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
    end
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b0; wclk(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b1; wclk(HALF);
  endtask

  // is_addr: byte is an address; exp_ack: block should acknowledge
  task automatic send_byte(input logic [7:0] b, input bit is_addr, input bit exp_ack,
                           input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(HALF);
      if (i == 0 && exp_ack && !is_addr) begin
        m_wr_val = b; wr_pend = 1'b1;
      end
      scl_m = 1'b1; wclk(HALF);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wclk(HALF);
    if (exp_ack && is_addr) snap_pend = 1'b1;
    scl_m = 1'b1; wclk(HALF);
    chk(tag, {31'd0, sda_pd}, {31'd0, exp_ack});
    scl_m = 1'b0; wclk(HALF);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    v = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      v = {v[6:0], sda_bus};
      scl_m = 1'b0;
    end
    wclk(HALF);
    sda_m = mack ? 1'b0 : 1'b1;
    wclk(HALF);
    scl_m = 1'b1; wclk(HALF);
    scl_m = 1'b0; wclk(HALF);
    sda_m = 1'b1;
  endtask

  initial begin
    logic [7:0] rv;
    mdl_on = 1'b0;
    rst_n = 1'b0; addr_sel = 2'b10; scl_m = 1'b1; sda_m = 1'b1; pin_drv = 8'hFF;
    wclk(6);
    rst_n = 1'b1;
    wclk(4);
    // R11 reset state
    chk("R11 pin_pd after reset", {24'd0, pin_pd}, 32'h0);
    chk("R11 int_n after reset", {31'd0, int_n}, 32'h1);
    chk("R11 sda_pd after reset", {31'd0, sda_pd}, 32'h0);
    mdl_on = 1'b1;

    // R1 R2 R4: burst write to address 0x36
    bus_start();
    send_byte(8'h6C, 1'b1, 1'b1, "R1 ack of matching write address");
    send_byte(8'h3C, 1'b0, 1'b1, "R2 ack data 3C");
    chk("R2 pin_pd after 3C", {24'd0, pin_pd}, 32'hC3);
    send_byte(8'hA5, 1'b0, 1'b1, "R4 ack data A5");
    send_byte(8'h00, 1'b0, 1'b1, "R4 ack data 00");
    send_byte(8'hFF, 1'b0, 1'b1, "R4 ack data FF");
    send_byte(8'h96, 1'b0, 1'b1, "R4 ack data 96");
    bus_stop();
    chk("R4 last byte held", {24'd0, pin_pd}, 32'h69);

    // R1 R9: non-matching address, data ignored
    bus_start();
    send_byte(8'h6A, 1'b1, 1'b0, "R1 no ack for address 35");
    send_byte(8'h11, 1'b0, 1'b0, "R9 no ack after mismatch");
    bus_stop();
    chk("R9 lines unchanged after mismatch", {24'd0, pin_pd}, 32'h69);

    // R6: pin change raises sticky interrupt
    pin_drv = 8'h5A; wclk(10);
    chk("R6 int_n low on change", {31'd0, int_n}, 32'h0);
    pin_drv = 8'hFF; wclk(10);
    chk("R6 int_n stays low", {31'd0, int_n}, 32'h0);
    pin_drv = 8'h5A; wclk(10);

    // R5 R7 R8: read returns snapshot
    bus_start();
    send_byte(8'h6D, 1'b1, 1'b1, "R8 ack of read address");
    chk("R7 int_n released by snapshot", {31'd0, int_n}, 32'h1);
    read_byte(1'b1, rv);
    chk("R8 first read byte", {24'd0, rv}, 32'h5A);
    pin_drv = 8'h0F;
    read_byte(1'b1, rv);
    chk("R5 snapshot not live pins", {24'd0, rv}, 32'h5A);
    chk("R6 int_n low after change in read", {31'd0, int_n}, 32'h0);
    read_byte(1'b0, rv);
    chk("R8 third read byte", {24'd0, rv}, 32'h5A);
    chk("R8 SDA released after nack", {31'd0, sda_pd}, 32'h0);
    bus_stop();

    // R5: write address snapshot clears interrupt
    bus_start();
    send_byte(8'h6C, 1'b1, 1'b1, "R5 ack write address");
    chk("R5 int_n released at write ack", {31'd0, int_n}, 32'h1);
    send_byte(8'h81, 1'b0, 1'b1, "R2 ack data 81");
    // R9: repeated starts
    bus_start();
    send_byte(8'h6A, 1'b1, 1'b0, "R9 no ack after repeated start mismatch");
    send_byte(8'h22, 1'b0, 1'b0, "R9 byte ignored");
    chk("R9 lines kept after ignored byte", {24'd0, pin_pd}, 32'h7E);
    bus_start();
    send_byte(8'h6C, 1'b1, 1'b1, "R9 ack after repeated start match");
    send_byte(8'h7E, 1'b0, 1'b1, "R2 ack data 7E");
    bus_stop();
    chk("R2 pin_pd after 7E", {24'd0, pin_pd}, 32'h81);

    // R10: clocks after STOP without START ignored
    scl_m = 1'b0; wclk(HALF);
    send_byte(8'h00, 1'b0, 1'b0, "R10 no ack without start");
    chk("R10 lines kept", {24'd0, pin_pd}, 32'h81);
    scl_m = 1'b1; wclk(HALF);
    sda_m = 1'b1; wclk(HALF);

    // R1: strap inputs change the address
    addr_sel = 2'b01; wclk(4);
    bus_start();
    send_byte(8'h6A, 1'b1, 1'b1, "R1 ack of address 35 with new straps");
    send_byte(8'hF0, 1'b0, 1'b1, "R2 ack data F0");
    bus_stop();
    chk("R2 pin_pd after F0", {24'd0, pin_pd}, 32'h0F);

    wclk(10);
    finish_run();
  end
endmodule